// File: doc/BRIEF.md
# Sticky Right Shifter, 128-bit

This block shifts a 128-bit operand right by a count from 0 to 255 and keeps, in the least significant bit of the result, a record of whether anything nonzero fell off the bottom. The operand arrives as two 64-bit words (upper and lower), and the result leaves the same way. A later rounding stage can then still tell an exactly aligned value from one that lost bits. That case matters when a narrower mantissa is aligned to a wider one before an addition.

The count range splits into four regions, each with its own datapath: no shift, a shift inside a word, a shift that crosses a whole word, and a shift that clears everything. The shift itself has no clock. A register on the operand side and a register on the result side can each be switched in by parameter, so the block can sit inside a pipeline stage or span one.

Top module: `srsh_top`

## Requirements
- R1: With a count of 0, the upper and lower result words equal the upper and lower input words.
- R2: With a count of 128 to 255, the upper result word is 0. The lower result word is 1 when any bit of either input word is set, and 0 when both are zero.
- R3: With a count of 64 to 127, the upper result word is 0. The lower result word is the upper input word shifted right by (count - 64), with bit 0 ORed with the OR of the whole lower input word and of every upper-word bit that fell below bit 0.
- R4: With a count of 1 to 63, the upper result word is the upper input word shifted right by the count. The lower result word is the lower input word shifted right by the count, with the vacated top positions filled by the lowest count bits of the upper input word.
- R5: With a count of 1 to 63, bit 0 of the lower result word is additionally ORed with the OR of the count lowest bits of the lower input word.
- R6: For every count, a nonzero 128-bit input never produces an all-zero result.
- R7: The latency from inputs to outputs is IN_REG + OUT_REG clock cycles, and an output does not change before that many rising edges have passed.
- R8: While rst_n is low, every enabled register holds zero, so both result words read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional registers and the checks |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_i | input | 64 | Upper word of the operand |
| lo_i | input | 64 | Lower word of the operand |
| cnt_i | input | 8 | Right-shift count |
| hi_o | output | 64 | Upper word of the shifted result |
| lo_o | output | 64 | Lower word of the shifted result, bit 0 carrying the sticky flag |

## Verification
The bench builds the block with both IN_REG and OUT_REG set to 1, so it sees a two-cycle path. With that setting it can observe the reset value of the registers and confirm that a new operand shows no change after the first rising edge. The shift regions and the sticky merge are the same logic at every register setting. The bench checks them at the region boundaries 0, 1, 63, 64, 65, 127, 128 and 255, and in a sweep of all 256 counts against a reference built on one 128-bit shift.

// File: rtl/srsh_pkg.sv
package srsh_pkg;

    // Count region chosen by the decoder; each selects its own datapath.
    typedef enum logic [1:0] {
        RGN_PASS = 2'd0,  // count of zero
        RGN_NEAR = 2'd1,  // shift within one word
        RGN_FAR  = 2'd2,  // shift crossing a full word
        RGN_ALL  = 2'd3   // shift past both words
    } region_t;

endpackage

// File: rtl/srsh_region.sv
module srsh_region
    import srsh_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic [CNT_W-1:0] cnt_i,
    output region_t          region_o
);

    localparam logic [CNT_W-1:0] NEAR_LIM = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] FAR_LIM  = CNT_W'(2 * WORD_W);

    always_comb begin
        if (cnt_i == '0)
            region_o = RGN_PASS;
        else if (cnt_i < NEAR_LIM)
            region_o = RGN_NEAR;
        else if (cnt_i < FAR_LIM)
            region_o = RGN_FAR;
        else
            region_o = RGN_ALL;
    end

endmodule

// File: rtl/srsh_core.sv
module srsh_core
    import srsh_pkg::*;
#(
    parameter  int WORD_W = 64,
    localparam int SH_W   = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] hi_i,
    input  logic [WORD_W-1:0] lo_i,
    input  logic [SH_W-1:0]   sh_i,
    input  region_t           region_i,
    output logic [WORD_W-1:0] hi_o,
    output logic [WORD_W-1:0] lo_o
);

    // Word width is a power of two, so the in-word amount for both the
    // near and far regions is the low SH_W bits of the count.
    logic [WORD_W-1:0] drop_mask;
    logic [SH_W-1:0]   fill_sh;
    logic [WORD_W-1:0] near_hi, near_lo, far_lo;
    logic              near_stk, far_stk, all_stk;

    always_comb begin
        drop_mask = ~({WORD_W{1'b1}} << sh_i);
        fill_sh   = SH_W'(0) - sh_i;  // WORD_W - sh for sh in 1..WORD_W-1
        near_hi   = hi_i >> sh_i;
        near_lo   = (lo_i >> sh_i) | (hi_i << fill_sh);
        near_stk  = |(lo_i & drop_mask);
        far_lo    = hi_i >> sh_i;
        far_stk   = (|lo_i) | (|(hi_i & drop_mask));
        all_stk   = (|hi_i) | (|lo_i);

        unique case (region_i)
            RGN_PASS: begin
                hi_o = hi_i;
                lo_o = lo_i;
            end
            RGN_NEAR: begin
                hi_o = near_hi;
                lo_o = {near_lo[WORD_W-1:1], near_lo[0] | near_stk};
            end
            RGN_FAR: begin
                hi_o = '0;
                lo_o = {far_lo[WORD_W-1:1], far_lo[0] | far_stk};
            end
            default: begin
                hi_o = '0;
                lo_o = {{(WORD_W-1){1'b0}}, all_stk};
            end
        endcase
    end

    AST_PASS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (region_i == RGN_PASS) |-> (hi_o == hi_i && lo_o == lo_i)); // R1
    AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (region_i == RGN_FAR || region_i == RGN_ALL) |-> (hi_o == '0)); // R3
    AST_ALL_ONLY_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (region_i == RGN_ALL) |-> (lo_o[WORD_W-1:1] == '0)); // R2
    AST_NONZERO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ({hi_i, lo_i} != '0) |-> ({hi_o, lo_o} != '0)); // R6
    AST_NEAR_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (region_i == RGN_NEAR) |-> ($countones(hi_o) <= $countones(hi_i))); // R4

endmodule

// File: rtl/srsh_top.sv
module srsh_top
    import srsh_pkg::*;
#(
    parameter  int WORD_W  = 64,
    parameter  int CNT_W   = 8,
    parameter  bit IN_REG  = 1'b0,
    parameter  bit OUT_REG = 1'b0,
    localparam int SH_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] hi_i,
    input  logic [WORD_W-1:0] lo_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [WORD_W-1:0] hi_o,
    output logic [WORD_W-1:0] lo_o
);

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic [CNT_W-1:0]  cnt;
    } opnd_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } rslt_t;

    opnd_t   opnd_d, opnd_q;
    rslt_t   rslt_d, rslt_q;
    region_t region;
    logic [WORD_W-1:0] core_hi, core_lo;

    always_comb begin
        opnd_d.hi  = hi_i;
        opnd_d.lo  = lo_i;
        opnd_d.cnt = cnt_i;
    end

    generate
        if (IN_REG) begin : g_in_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) opnd_q <= '0;
                else        opnd_q <= opnd_d;
            end
        end else begin : g_in_wire
            assign opnd_q = opnd_d;
        end
    endgenerate

    srsh_region #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W)
    ) u_region (
        .cnt_i    (opnd_q.cnt),
        .region_o (region)
    );

    srsh_core #(
        .WORD_W (WORD_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_i     (opnd_q.hi),
        .lo_i     (opnd_q.lo),
        .sh_i     (opnd_q.cnt[SH_W-1:0]),
        .region_i (region),
        .hi_o     (core_hi),
        .lo_o     (core_lo)
    );

    always_comb begin
        rslt_d.hi = core_hi;
        rslt_d.lo = core_lo;
    end

    generate
        if (OUT_REG) begin : g_out_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rslt_q <= '0;
                else        rslt_q <= rslt_d;
            end
        end else begin : g_out_wire
            assign rslt_q = rslt_d;
        end
    endgenerate

    assign hi_o = rslt_q.hi;
    assign lo_o = rslt_q.lo;

endmodule

// File: tb/srsh_top_tb.sv
module srsh_top_tb;

    localparam int W   = 64;
    localparam int CW  = 8;
    localparam int NV  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  hi_i = '0, lo_i = '0;
    logic [CW-1:0] cnt_i = '0;
    logic [W-1:0]  hi_o, lo_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    srsh_top #(.WORD_W(W), .CNT_W(CW), .IN_REG(1'b1), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .hi_i(hi_i), .lo_i(lo_i), .cnt_i(cnt_i),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    // {hi, lo, cnt}
    localparam logic [2*W+CW-1:0] VEC [NV] = '{
        {64'hDEADBEEF01234567, 64'h89ABCDEFFEDCBA98, 8'd0},
        {64'hDEADBEEF01234567, 64'h89ABCDEFFEDCBA99, 8'd1},
        {64'h0000000000000000, 64'h0000000000000001, 8'd1},
        {64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000, 8'd63},
        {64'h8000000000000000, 64'h0000000000000000, 8'd64},
        {64'h0000000000000003, 64'h0000000000000000, 8'd65},
        {64'h0000000000000001, 64'h0000000000000000, 8'd127},
        {64'h8000000000000000, 64'h0000000000000001, 8'd127},
        {64'h0000000000000000, 64'h0000000000000010, 8'd128},
        {64'h0000000000000000, 64'h0000000000000000, 8'd255},
        {64'h0000000000000123, 64'h0000000000000000, 8'd255},
        {64'h0000000000000000, 64'h8000000000000000, 8'd64}
    };

    // Reference: one wide shift, OR of every dropped bit into bit 0.
    function automatic logic [2*W-1:0] ref_shift(logic [W-1:0] h, logic [W-1:0] l,
                                                 logic [CW-1:0] c);
        logic [2*W-1:0] full, res, dropped;
        full = {h, l};
        if (c == 0) return full;
        if (c >= 2*W) return {{(2*W-1){1'b0}}, |full};
        res     = full >> c;
        dropped = full & ~({(2*W){1'b1}} << c);
        res[0]  = res[0] | (|dropped);
        return res;
    endfunction

    function automatic string req_of(logic [CW-1:0] c);
        if (c == 0)   return "R1";
        if (c < W)    return "R4";
        if (c < 2*W)  return "R3";
        return "R2";
    endfunction

    task automatic check(string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] h, logic [W-1:0] l, logic [CW-1:0] c);
        @(negedge clk);
        hi_i = h; lo_i = l; cnt_i = c;
        @(posedge clk);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset clears the registers even with live inputs
        hi_i = 64'hFFFF0000FFFF0000; lo_i = 64'h1234; cnt_i = 8'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R8", {hi_o, lo_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk over region boundaries (R1..R4)
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] h, l;
            logic [CW-1:0] c;
            {h, l, c} = VEC[i];
            apply(h, l, c);
            check(req_of(c), {hi_o, lo_o}, ref_shift(h, l, c));
        end

        // R5: low-word sticky alone, for every in-word count
        for (int c = 1; c < W; c++) begin
            apply(64'h0, 64'h1, CW'(c));
            check("R5", {hi_o, lo_o}, {64'h0, 64'h1});
        end

        // R6: single bit at various places never vanishes, all counts
        for (int c = 0; c < 256; c++) begin
            logic [W-1:0] h, l;
            h = (c % 3 == 0) ? 64'h1 << (c % W) : 64'h0;
            l = (c % 3 == 0) ? 64'h0 : 64'h1 << ((c * 7) % W);
            apply(h, l, CW'(c));
            check("R6", {hi_o, lo_o}, ref_shift(h, l, CW'(c)));
            if ({hi_o, lo_o} == '0) check("R6", {hi_o, lo_o}, 128'h1);
        end

        // R7: two-cycle latency, no change after only one edge
        apply(64'h0, 64'h0, 8'd200);
        check("R2", {hi_o, lo_o}, '0);
        @(negedge clk);
        hi_i = 64'hA5A5A5A5A5A5A5A5; lo_i = 64'h5A5A5A5A5A5A5A5A; cnt_i = 8'd0;
        @(posedge clk);
        #1;
        check("R7", {hi_o, lo_o}, '0);
        @(posedge clk);
        #1;
        check("R7", {hi_o, lo_o}, {64'hA5A5A5A5A5A5A5A5, 64'h5A5A5A5A5A5A5A5A});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule